// File: doc/BRIEF.md
# Fine-Resolution PWM Generator with Buffered Duty

This block is a pulse-width modulator that drives a single output. An 8-bit period timer counts at a selectable rate. Below the timer sits a 2-bit fine counter. Together they form a 10-bit position within each period, so the duty cycle has four times the resolution of the timer.

Software writes three registers through a simple write port: a period, the upper eight bits of the duty value, and a control byte. The control byte carries the two low duty bits, the rate select, the timer run bit and the PWM mode bit. Duty writes land in a holding register. The comparator uses a separate shadow copy, which is refreshed only at the end of a period, so a write made mid-period cannot shorten or stretch the pulse in progress.

A typical bring-up proceeds in four steps:
1. Program the period.
2. Program the duty value.
3. Set the rate and start the timer.
4. Turn on PWM mode.

The output first goes high at the next period boundary.

Top module: `fine_pwm`

## Requirements
- R1: After reset the output is low and the period, duty and control registers are all zero.
- R2: With the timer running and rate divider N, one period lasts (P+1)*4*N clock cycles, where P is the period register.
- R3: The output is high for D*N clock cycles per period, where D = {duty_high, ctrl[1:0]} is the 10-bit duty value; a change in only the two low bits changes the high time by whole fine steps.
- R4: Control bits [3:2] select the rate divider: 0 gives N=1, 1 gives N=4, 2 or 3 gives N=16.
- R5: The comparator uses a shadow duty value that changes only at a period boundary, where it takes the written duty; a duty write during a period leaves that period's pulse unchanged.
- R6: When D exceeds the last position of the period (4*P+3), the output stays high for the entire period.
- R7: When D is 0 the output stays low for the entire period; at the boundary, clear wins over set.
- R8: When control bit 4 (timer run) is 0, the rate divider, timer and fine count are held at zero and the output is low from the next cycle.
- R9: When control bit 5 (PWM mode) is 0 the output is low, and the output can only rise on the cycle after a period boundary.
- R10: Writes use address 0 for the period, 1 for the duty high byte and 2 for control; a write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 period, 1 duty high, 2 control) |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated output |

## Verification
The embedded properties check these rules on every cycle:
- Counters are held at zero while the timer is stopped, and the output is low.
- The position returns to zero right after a period match.
- The shadow duty moves only on a boundary, and then to the written value.
- The output never rises except just after a boundary, and a zero duty yields no pulse.

Only the directed scenarios can show the measured quantities: actual high times and period lengths for each rate setting, the effect of the two fine duty bits, the old-then-new pulse sequence after a mid-period write, and the saturated always-high and always-low cases.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
   typedef enum logic [1:0] {
      ADR_PERIOD  = 2'd0,
      ADR_DUTY_HI = 2'd1,
      ADR_CTRL    = 2'd2
   } fpwm_addr_e;

   localparam int CTL_DLO_LSB  = 0;
   localparam int CTL_RATE_LSB = 2;
   localparam int CTL_RUN_BIT  = 4;
   localparam int CTL_MODE_BIT = 5;
endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
   parameter int STAGES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       step
);
   localparam int PRE_W = (STAGES > 1) ? 2 * (STAGES - 1) : 1;
   localparam logic [1:0] SEL_MAX = 2'(STAGES - 1);

   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("fpwm_prescaler: STAGES must be 1..4");
   end

   logic [3:0]       hit;
   logic [1:0]       sel_eff;
   logic [PRE_W-1:0] cnt_q;

   assign sel_eff = (sel > SEL_MAX) ? SEL_MAX : sel;

   for (genvar k = 0; k < 4; k++) begin : g_hit
      if (k == 0) begin : g_first
         assign hit[k] = 1'b1;
      end else if (k < STAGES) begin : g_used
         assign hit[k] = &cnt_q[2*k-1:0];
      end else begin : g_none
         assign hit[k] = 1'b0;
      end
   end

   assign step = run & hit[sel_eff];

   if (STAGES > 1) begin : g_counter
      always_ff @(posedge clk) begin
         if (!rst_n || !run) cnt_q <= '0;
         else if (step)      cnt_q <= '0;
         else                cnt_q <= cnt_q + PRE_W'(1);
      end
   end else begin : g_bypass
      always_ff @(posedge clk) cnt_q <= '0;
   end

   // R8
   pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));
endmodule

// File: rtl/fpwm_timebase.sv
module fpwm_timebase #(
   parameter int TMR_W  = 8,
   parameter int FINE_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic                      step,
   input  logic [TMR_W-1:0]          period,
   output logic [TMR_W+FINE_W-1:0]   position,
   output logic                      wrap
);
   localparam int POS_W = TMR_W + FINE_W;

   if (FINE_W < 1 || TMR_W < 2) begin : g_bad_width
      $error("fpwm_timebase: widths too small");
   end

   logic [POS_W-1:0] pos_q;
   logic [TMR_W-1:0] tmr;
   logic [FINE_W-1:0] fine;

   assign tmr  = pos_q[POS_W-1:FINE_W];
   assign fine = pos_q[FINE_W-1:0];
   assign wrap = step & (&fine) & (tmr == period);
   assign position = pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) pos_q <= '0;
      else if (wrap)      pos_q <= '0;
      else if (step)      pos_q <= pos_q + POS_W'(1);
   end

   // R2
   wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (position == '0));
   // R8
   tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (position == '0));
endmodule

// File: rtl/fpwm_duty_buf.sv
module fpwm_duty_buf #(
   parameter int DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DUTY_W-1:0] duty_in,
   output logic [DUTY_W-1:0] shadow
);
   if (DUTY_W < 2) begin : g_bad_duty
      $error("fpwm_duty_buf: DUTY_W too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    shadow <= '0;
      else if (load) shadow <= duty_in;
   end

   // R5
   shadow_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(shadow));
   // R5
   shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (shadow == $past(duty_in)));
endmodule

// File: rtl/fine_pwm.sv
module fine_pwm
   import fpwm_pkg::*;
#(
   parameter int TMR_W       = 8,
   parameter int FINE_W      = 2,
   parameter int RATE_STAGES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       pwm_out
);
   localparam int DUTY_W = TMR_W + FINE_W;

   if (TMR_W != 8 || FINE_W != 2) begin : g_bad_map
      $error("fine_pwm: register map assumes an 8-bit timer and 2-bit fine count");
   end

   logic [TMR_W-1:0]  period_q;
   logic [TMR_W-1:0]  duty_hi_q;
   logic [FINE_W-1:0] duty_lo_q;
   logic [1:0]        rate_q;
   logic              run_q;
   logic              mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q  <= '0;
         duty_hi_q <= '0;
         duty_lo_q <= '0;
         rate_q    <= '0;
         run_q     <= 1'b0;
         mode_q    <= 1'b0;
      end else if (wr_en) begin
         case (fpwm_addr_e'(wr_addr))
            ADR_PERIOD:  period_q  <= wr_data;
            ADR_DUTY_HI: duty_hi_q <= wr_data;
            ADR_CTRL: begin
               duty_lo_q <= wr_data[CTL_DLO_LSB +: FINE_W];
               rate_q    <= wr_data[CTL_RATE_LSB +: 2];
               run_q     <= wr_data[CTL_RUN_BIT];
               mode_q    <= wr_data[CTL_MODE_BIT];
            end
            default: ;
         endcase
      end
   end

   logic              step;
   logic              wrap;
   logic [DUTY_W-1:0] position;
   logic [DUTY_W-1:0] duty_wr;
   logic [DUTY_W-1:0] shadow;
   logic              match;

   assign duty_wr = {duty_hi_q, duty_lo_q};

   fpwm_prescaler #(.STAGES(RATE_STAGES)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q), .sel(rate_q), .step(step)
   );

   fpwm_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(run_q), .step(step),
      .period(period_q), .position(position), .wrap(wrap)
   );

   fpwm_duty_buf #(.DUTY_W(DUTY_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .load(wrap), .duty_in(duty_wr), .shadow(shadow)
   );

   assign match = step & ((position + DUTY_W'(1)) == shadow);

   always_ff @(posedge clk) begin
      if (!rst_n || !run_q || !mode_q) pwm_out <= 1'b0;
      else if (wrap)                   pwm_out <= (duty_wr != '0);
      else if (match)                  pwm_out <= 1'b0;
   end

   // R9
   rise_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> $past(wrap));
   // R8
   stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> !pwm_out);
   // R9
   mode_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |=> !pwm_out);
   // R7
   zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && duty_wr == '0) |=> !pwm_out);
endmodule

// File: tb/fine_pwm_bench.sv
module fine_pwm_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       pwm_out;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fine_pwm u_fine_pwm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [7:0] ctl(input int dlo, input int rate, input bit run, input bit mode);
      return {2'b00, mode, run, 2'(rate), 2'(dlo)};
   endfunction

   task automatic setup(input int p, input int d, input int rate);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'(p));
      wr(2'd1, 8'(d >> 2));
      wr(2'd2, ctl(d & 3, rate, 1'b1, 1'b0));
      wr(2'd2, ctl(d & 3, rate, 1'b1, 1'b1));
   endtask

   task automatic wait_rise(output bit ok);
      bit prev;
      ok = 1'b0;
      @(negedge clk);
      prev = pwm_out;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (pwm_out && !prev) begin
            ok = 1'b1;
            break;
         end
         prev = pwm_out;
      end
   endtask

   task automatic measure(output int hi, output int per);
      bit ok, prev, low;
      wait_rise(ok);
      hi = 1; per = 1; prev = 1'b1; low = 1'b0;
      if (!ok) begin
         hi = -1; per = -1;
         return;
      end
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (pwm_out && !prev) break;
         per++;
         if (!pwm_out) low = 1'b1;
         if (pwm_out && !low) hi++;
         prev = pwm_out;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      // R1
      chk(pwm_out == 1'b0, "R1 output low after reset", int'(pwm_out), 0);
   endtask

   task automatic t_basic;
      int hi, per;
      setup(9, 17, 0);
      measure(hi, per);
      measure(hi, per);
      chk(hi == 17, "R3 high time P=9 D=17 N=1", hi, 17);
      chk(per == 40, "R2 period P=9 N=1", per, 40);
      // R10 write of control only (low duty bits)
      wr(2'd2, ctl(2, 0, 1'b1, 1'b1));
      measure(hi, per);
      measure(hi, per);
      chk(hi == 18, "R3 fine step D=18", hi, 18);
      chk(per == 40, "R10 period kept after control write", per, 40);
   endtask

   task automatic t_rate4;
      int hi, per;
      setup(4, 7, 1);
      measure(hi, per);
      measure(hi, per);
      chk(hi == 28, "R4 high time N=4", hi, 28);
      chk(per == 80, "R4 period N=4", per, 80);
   endtask

   task automatic t_rate16;
      int hi, per;
      setup(2, 5, 2);
      measure(hi, per);
      measure(hi, per);
      chk(hi == 80, "R4 high time N=16", hi, 80);
      chk(per == 192, "R4 period N=16", per, 192);
      wr(2'd2, ctl(1, 3, 1'b1, 1'b1));
      measure(hi, per);
      measure(hi, per);
      chk(per == 192, "R4 select 3 behaves as N=16", per, 192);
   endtask

   task automatic t_dbuf;
      int hi, per;
      bit ok, low;
      setup(9, 10, 0);
      measure(hi, per);
      wait_rise(ok);
      hi = 1; low = 1'b0;
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd7;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (i == 0) wr_en = 1'b0;
         if (!pwm_out) low = 1'b1;
         if (pwm_out && !low) hi++;
      end
      // R5 current pulse keeps the old duty
      chk(ok && hi == 10, "R5 pulse during write keeps old duty", hi, 10);
      measure(hi, per);
      chk(hi == 30, "R5 new duty in following period", hi, 30);
   endtask

   task automatic t_over;
      int highs;
      setup(3, 20, 0);
      repeat (40) @(negedge clk);
      highs = 0;
      for (int i = 0; i < 48; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      // R6
      chk(highs == 48, "R6 duty above period stays high", highs, 48);
   endtask

   task automatic t_zero;
      int highs;
      setup(3, 0, 0);
      highs = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      // R7
      chk(highs == 0, "R7 zero duty stays low", highs, 0);
   endtask

   task automatic t_off;
      int highs, hi, per;
      setup(9, 30, 0);
      measure(hi, per);
      wr(2'd2, ctl(0, 0, 1'b0, 1'b1));
      highs = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      // R8
      chk(highs == 0, "R8 timer stopped output low", highs, 0);
      wr(2'd2, ctl(2, 0, 1'b1, 1'b0));
      highs = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      // R9
      chk(highs == 0, "R9 mode off output low", highs, 0);
      wr(2'd2, ctl(2, 0, 1'b1, 1'b1));
      measure(hi, per);
      measure(hi, per);
      chk(per == 40, "R8 restart period after stop", per, 40);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_rate4();
      t_rate16();
      t_dbuf();
      t_over();
      t_zero();
      t_off();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule